// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration registers of a PCI-to-PCI bridge that acts as a root port. It stores the 64-byte type-1 header and, when the `HAS_CAP` parameter is set, a PCI Express capability structure that starts right after the header at byte 0x40. Every bit of every implemented dword has one fixed attribute: read-only, read-write, write-1-to-clear or reserved. All reads and writes obey those attributes.

Requests arrive on a simple port. The port carries a byte address, whose low two bits are the byte offset inside the dword, an access size of 1, 2 or 4 bytes, right-justified write data and a write flag. Every request gets a response one clock later, with read data and an error flag. A partial write reads the whole stored dword, merges in the enabled byte lanes according to the bit attributes, and stores the result in the same cycle. Logic beside the block raises write-1-to-clear status bits through a set port. That port names a dword index and a bit pattern.

Top module: `bcfg_regfile`

## Requirements
- R1: After reset the dwords read as follows. Byte 0x00 reads {DEVICE_ID, VENDOR_ID}. Byte 0x04 reads 0x0010_0000, which is the capability-list status bit. Byte 0x08 reads {0x060400, REV_ID}. Byte 0x0C reads 0x0001_0010, which is header type 1 and cache line size 0x10. The capability pointer at 0x34 reads 0x40 with the capability and 0x00 without it. With the capability, 0x40 reads 0x0142_0010, which is ID 0x10 with version 2, root-port type and the slot-implemented flag. Every other dword reads zero.
- R2: Reserved bits always read zero, even after a write of all ones. Examples: the capability pointer dword keeps bits 31:8 at zero, and the expansion ROM dword at 0x38 keeps bits 10:1 at zero.
- R3: A read returns the response one cycle after the request, with data aligned to bit 0. Size 1 returns (dword >> 8*offset) & 0xFF. Size 2 returns (dword >> 8*offset) & 0xFFFF. Size 4 returns the whole dword whatever the offset.
- R4: A size other than 1, 2 or 4 inside the implemented region sets the error flag. The response returns zero data, and a write of that size changes nothing.
- R5: A write shifts its data left by 8*offset. It then updates only the read-write bits inside the lane mask. The lane mask is 0xFF << 8*offset for size 1, 0xFFFF << 8*offset for size 2 (truncated to 32 bits), and all ones for size 4. No other bit changes.
- R6: Writes never change read-only bits. Example: a write of all ones to 0x00 leaves the ID dword as it was.
- R7: A write-1-to-clear bit inside the lane mask clears when the shifted data holds a 1 there. A 0 leaves the bit unchanged.
- R8: A set pulse raises exactly the write-1-to-clear bits of the named dword that are 1 in the set pattern. Other bits ignore it. If a set and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R9: Accesses at or above the end of the implemented region read zero with no error, even for an invalid size, and their writes are dropped. Without the capability the region ends at byte 0x40. With the capability it ends at byte 0x7C.
- R10: At 0x04, command bits 0, 1, 2, 6 and 8 are read-write and status bits 24 and 27–31 are write-1-to-clear. At 0x18, bits 23:0 are read-write and bits 31:24 are read-only. At 0x20 and 0x24, bits 31:20 and 15:4 are read-write. At 0x3C, the read-write mask is 0x0B6F_00FF.
- R11: The capability's device-status dword (0x48) has bits 19:16 write-1-to-clear and bits 15:0 read-write. The link dword (0x50) has bits 31:30 write-1-to-clear and read-write mask 0x0FFB. The root-status dword (0x60) has bit 16 write-1-to-clear.
- R12: Every request, read or write, produces exactly one response-valid pulse one cycle later. A write returns zero data, and a cycle with no request returns no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 are the offset within the dword |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, right-justified |
| set_valid | input | 1 | Hardware set pulse present |
| set_idx | input | ADDR_W-2 | Dword index targeted by the set pulse |
| set_bits | input | 32 | Bits to raise (write-1-to-clear bits only) |
| rsp_valid | output | 1 | Response strobe, one cycle after a request |
| rsp_rdata | output | 32 | Read data, aligned to bit 0 |
| rsp_err | output | 1 | Invalid access size |

## Verification
The hardest case to bring about is a hardware set pulse and a clearing write that reach the same write-1-to-clear bit in the same clock. The same write also clears a neighbouring bit, so the bench can see that the set wins on one bit and the clear still acts on the other. The bench raises the set inputs in the same cycle as the write request, after first loading the status bits through an earlier set pulse. The lane logic is covered by sweeps over every offset and size on a fully writable dword and on a read-only dword with known contents. A second instance built without the capability shows that the end of the region moves with the parameter.

// File: rtl/bcfg_pkg.sv
package bcfg_pkg;

    localparam int WORD_W     = 32;
    localparam int HDR_DWORDS = 16;
    localparam int CAP_DWORDS = 15;

    localparam logic [2:0] SZ_BYTE = 3'd1;
    localparam logic [2:0] SZ_HALF = 3'd2;
    localparam logic [2:0] SZ_WORD = 3'd4;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t rw;
        word_t w1c;
        word_t rsvd;
    } attr_t;

    typedef struct packed {
        logic  hit;
        logic  size_ok;
        logic  [4:0] shift;
        word_t lane;
        word_t data;
    } access_t;

    function automatic attr_t dword_attr(int idx);
        attr_t a;
        a = '0;
        case (idx)
            1:  begin a.rw = 32'h0000_0147; a.w1c = 32'hF900_0000; a.rsvd = 32'h004F_FC00; end
            6:  begin a.rw = 32'h00FF_FFFF; end
            7:  begin a.rw = 32'h0000_F0F0; a.w1c = 32'hF900_0000; a.rsvd = 32'h005F_0000; end
            8,
            9:  begin a.rw = 32'hFFF0_FFF0; end
            10,
            11,
            12: begin a.rw = 32'hFFFF_FFFF; end
            13: begin a.rsvd = 32'hFFFF_FF00; end
            14: begin a.rw = 32'hFFFF_F801; a.rsvd = 32'h0000_07FE; end
            15: begin a.rw = 32'h0B6F_00FF; a.w1c = 32'h0400_0000; a.rsvd = 32'hF010_0000; end
            18: begin a.rw = 32'h0000_FFFF; a.w1c = 32'h000F_0000; a.rsvd = 32'hFFE0_0000; end
            19: begin a.rsvd = 32'h0080_0000; end
            20: begin a.rw = 32'h0000_0FFB; a.w1c = 32'hC000_0000; a.rsvd = 32'h0000_F004; end
            22: begin a.rw = 32'h0000_1FFF; a.w1c = 32'h011F_0000; a.rsvd = 32'hFE00_E000; end
            23: begin a.rw = 32'h0000_001F; a.rsvd = 32'hFFFE_FFE0; end
            24: begin a.w1c = 32'h0001_0000; a.rsvd = 32'hFFFC_0000; end
            default: a = '0;
        endcase
        return a;
    endfunction

    function automatic word_t dword_init(int idx, logic [15:0] vid, logic [15:0] did,
                                         logic [7:0] rev, bit has_cap);
        word_t v;
        case (idx)
            0:       v = {did, vid};
            1:       v = 32'h0010_0000;
            2:       v = {24'h060400, rev};
            3:       v = 32'h0001_0010;
            13:      v = has_cap ? 32'h0000_0040 : 32'h0;
            16:      v = has_cap ? 32'h0142_0010 : 32'h0;
            default: v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/bcfg_decode.sv
module bcfg_decode
    import bcfg_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int NUM_DW = 31
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size,
    input  word_t             wdata,
    output logic [ADDR_W-3:0] idx,
    output access_t           acc
);
    localparam int IDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_DW);

    assign idx       = addr[ADDR_W-1:2];
    assign acc.hit   = (idx < LIMIT);
    assign acc.shift = {addr[1:0], 3'b000};
    assign acc.data  = wdata << acc.shift;

    always_comb begin
        acc.size_ok = 1'b1;
        case (size)
            SZ_BYTE: acc.lane = 32'h0000_00FF << acc.shift;
            SZ_HALF: acc.lane = 32'h0000_FFFF << acc.shift;
            SZ_WORD: acc.lane = 32'hFFFF_FFFF;
            default: begin
                acc.lane    = '0;
                acc.size_ok = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/bcfg_dword.sv
module bcfg_dword
    import bcfg_pkg::*;
#(
    parameter int          IDX       = 0,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h1234,
    parameter logic [7:0]  REV_ID    = 8'h01,
    parameter bit          HAS_CAP   = 1'b1
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  wr_en,
    input  word_t wr_lane,
    input  word_t wr_data,
    input  logic  set_en,
    input  word_t set_bits,
    output word_t q
);
    localparam attr_t A      = dword_attr(IDX);
    localparam word_t RW_M   = A.rw;
    localparam word_t W1C_M  = A.w1c;
    localparam word_t RSVD_M = A.rsvd;
    localparam word_t RO_M   = ~(RW_M | W1C_M | RSVD_M);
    localparam word_t INIT   = dword_init(IDX, VENDOR_ID, DEVICE_ID, REV_ID, HAS_CAP) & ~RSVD_M;

    word_t cur, nxt, upd, clr, raise;

    always_comb begin
        upd   = wr_en  ? (wr_lane & RW_M)           : '0;
        clr   = wr_en  ? (wr_lane & W1C_M & wr_data) : '0;
        raise = set_en ? (set_bits & W1C_M)          : '0;
        nxt   = (cur & ~upd) | (wr_data & upd);
        nxt   = (nxt & ~clr) | raise;
        nxt   = nxt & ~RSVD_M;
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= INIT;
        else     cur <= nxt;
    end

    assign q = cur;

    assert_ro_stable_R6: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((q & RO_M) == $past(q & RO_M)));

    assert_w1c_rise_only_by_set_R7: assert property (@(posedge clk) disable iff (rst)
        !set_en |=> ((q & ~$past(q) & W1C_M) == '0));

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (rst)
        set_en |=> ((q & $past(set_bits & W1C_M)) == $past(set_bits & W1C_M)));
endmodule

// File: rtl/bcfg_regfile.sv
module bcfg_regfile
    import bcfg_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter bit          HAS_CAP   = 1'b1,
    parameter logic [15:0] VENDOR_ID = 16'hABCD,
    parameter logic [15:0] DEVICE_ID = 16'h1234,
    parameter logic [7:0]  REV_ID    = 8'h01
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_size,
    input  logic [31:0]       req_wdata,
    input  logic              set_valid,
    input  logic [ADDR_W-3:0] set_idx,
    input  logic [31:0]       set_bits,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_err
);
    localparam int IDX_W  = ADDR_W - 2;
    localparam int NUM_DW = HDR_DWORDS + (HAS_CAP ? CAP_DWORDS : 0);

    logic [IDX_W-1:0] dec_idx;
    access_t          acc;
    word_t            dw_q [NUM_DW];
    word_t            sel, shifted, rd_val;
    logic             wr_go;

    bcfg_decode #(.ADDR_W(ADDR_W), .NUM_DW(NUM_DW)) u_decode (
        .addr  (req_addr),
        .size  (req_size),
        .wdata (req_wdata),
        .idx   (dec_idx),
        .acc   (acc)
    );

    assign wr_go = req_valid & req_write & acc.hit & acc.size_ok;

    for (genvar i = 0; i < NUM_DW; i++) begin : g_dw
        bcfg_dword #(
            .IDX(i), .VENDOR_ID(VENDOR_ID), .DEVICE_ID(DEVICE_ID),
            .REV_ID(REV_ID), .HAS_CAP(HAS_CAP)
        ) u_dw (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_go && (dec_idx == IDX_W'(i))),
            .wr_lane  (acc.lane),
            .wr_data  (acc.data),
            .set_en   (set_valid && (set_idx == IDX_W'(i))),
            .set_bits (set_bits),
            .q        (dw_q[i])
        );
    end

    always_comb begin
        sel = '0;
        for (int i = 0; i < NUM_DW; i++) begin
            if (dec_idx == IDX_W'(i)) sel = dw_q[i];
        end
        shifted = sel >> acc.shift;
        case (req_size)
            SZ_BYTE: rd_val = {24'b0, shifted[7:0]};
            SZ_HALF: rd_val = {16'b0, shifted[15:0]};
            default: rd_val = sel;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid & acc.hit & ~acc.size_ok;
            rsp_rdata <= (req_valid & ~req_write & acc.hit & acc.size_ok) ? rd_val : '0;
        end
    end

    assert_rsp_follows_req_R12: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R12: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_rdata == '0));

    assert_byte_read_width_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_size == SZ_BYTE) |=> (rsp_rdata[31:8] == '0));

    assert_outside_reads_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !acc.hit) |=> (rsp_rdata == '0 && !rsp_err));
endmodule

// File: tb/tb_bcfg_regfile.sv
module tb_bcfg_regfile;
    localparam logic [15:0] VID = 16'hABCD;
    localparam logic [15:0] DID = 16'h1234;
    localparam logic [7:0]  REV = 8'h01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 0, req_write = 0;
    logic [11:0] req_addr = '0;
    logic [2:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        set_valid = 0;
    logic [9:0]  set_idx = '0;
    logic [31:0] set_bits = '0;
    logic        rsp_valid, rsp_err, nc_valid, nc_err;
    logic [31:0] rsp_rdata, nc_rdata;

    logic        r_vld, r_err, n_err;
    logic [31:0] r_data, n_data;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    bcfg_regfile #(.ADDR_W(12), .HAS_CAP(1'b1), .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .set_valid(set_valid), .set_idx(set_idx),
        .set_bits(set_bits), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err));

    bcfg_regfile #(.ADDR_W(12), .HAS_CAP(1'b0), .VENDOR_ID(VID), .DEVICE_ID(DID), .REV_ID(REV)) dut_nocap (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .set_valid(set_valid), .set_idx(set_idx),
        .set_bits(set_bits), .rsp_valid(nc_valid), .rsp_rdata(nc_rdata), .rsp_err(nc_err));

    function automatic logic [31:0] exp_init(int i, bit cap);
        case (i)
            0:  return {DID, VID};
            1:  return 32'h0010_0000;
            2:  return {24'h060400, REV};
            3:  return 32'h0001_0010;
            13: return cap ? 32'h40 : 32'h0;
            16: return cap ? 32'h0142_0010 : 32'h0;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a falling edge; returns at the next falling edge with the response captured.
    task automatic acc(bit wr, int addr, int sz, logic [31:0] wd);
        req_valid = 1'b1; req_write = wr; req_addr = addr[11:0];
        req_size = sz[2:0]; req_wdata = wd;
        @(negedge clk);
        r_vld = rsp_valid; r_data = rsp_rdata; r_err = rsp_err;
        n_data = nc_rdata; n_err = nc_err;
        req_valid = 1'b0; req_write = 1'b0; set_valid = 1'b0;
    endtask

    task automatic hwset(int idx, logic [31:0] bits);
        set_valid = 1'b1; set_idx = idx[9:0]; set_bits = bits;
        @(negedge clk);
        set_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        logic [31:0] pat, lane, v, e;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R12: no request, no response
        chk("R12 idle rsp_valid", {31'b0, rsp_valid}, 32'h0);

        // R1: reset sweep of all implemented dwords, both configurations
        for (int i = 0; i < 31; i++) begin
            acc(0, i * 4, 4, 0);
            chk("R1 reset value", r_data, exp_init(i, 1'b1));
            if (i < 16) chk("R1 reset value no-cap", n_data, exp_init(i, 1'b0));
            else        chk("R9 no-cap beyond header reads zero", n_data, 32'h0);
        end
        chk("R12 read rsp_valid", {31'b0, r_vld}, 32'h1);

        // R3: read sweep of every offset and size on a read-only dword
        v = 32'h0001_0010;
        for (int off = 0; off < 4; off++) begin
            for (int s = 0; s < 3; s++) begin
                int sz;
                sz = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                e = v >> (8 * off);
                if (sz == 1) e = e & 32'hFF;
                else if (sz == 2) e = e & 32'hFFFF;
                else e = v;
                acc(0, 12 + off, sz, 0);
                chk("R3 sized read", r_data, e);
            end
        end

        // R5: write sweep of every offset and size on a fully writable dword
        pat = 32'hA5C3_96E1;
        for (int off = 0; off < 4; off++) begin
            for (int s = 0; s < 3; s++) begin
                int sz;
                sz = (s == 0) ? 1 : (s == 1) ? 2 : 4;
                lane = (sz == 4) ? 32'hFFFF_FFFF :
                       (sz == 2) ? (32'h0000_FFFF << (8 * off)) : (32'h0000_00FF << (8 * off));
                acc(1, 40, 4, 32'h0);
                acc(1, 40 + off, sz, pat);
                chk("R12 write returns zero data", r_data, 32'h0);
                acc(0, 40, 4, 0);
                e = pat << (8 * off);
                chk("R5 lane write", r_data, e & lane);
            end
        end

        // R4: invalid sizes inside the region
        acc(1, 44, 4, 32'h1234_5678);
        acc(1, 44, 3, 32'hFFFF_FFFF);
        chk("R4 bad size write err", {31'b0, r_err}, 32'h1);
        acc(0, 44, 4, 0);
        chk("R4 bad size write no change", r_data, 32'h1234_5678);
        acc(0, 44, 0, 0);
        chk("R4 bad size read err", {31'b0, r_err}, 32'h1);
        chk("R4 bad size read data", r_data, 32'h0);

        // R6 / R2: read-only and reserved bits
        acc(1, 0, 4, 32'hFFFF_FFFF);
        acc(0, 0, 4, 0);
        chk("R6 id dword unchanged", r_data, {DID, VID});
        acc(1, 52, 4, 32'hFFFF_FFFF);
        acc(0, 52, 4, 0);
        chk("R2 cap pointer reserved bits", r_data, 32'h0000_0040);
        acc(1, 56, 4, 32'hFFFF_FFFF);
        acc(0, 56, 4, 0);
        chk("R2 rom dword reserved bits", r_data, 32'hFFFF_F801);

        // R10: header masks
        acc(1, 4, 4, 32'hFFFF_FFFF);
        acc(0, 4, 4, 0);
        chk("R10 command write", r_data, 32'h0010_0147);
        acc(1, 24, 4, 32'hFFFF_FFFF);
        acc(0, 24, 4, 0);
        chk("R10 bus numbers", r_data, 32'h00FF_FFFF);
        acc(1, 32, 4, 32'hFFFF_FFFF);
        acc(0, 32, 4, 0);
        chk("R10 memory base/limit", r_data, 32'hFFF0_FFF0);
        acc(1, 60, 4, 32'hFFFF_FFFF);
        acc(0, 60, 4, 0);
        chk("R10 interrupt/bridge control", r_data, 32'h0B6F_00FF);

        // R8 / R7: status bits raised by hardware, cleared by byte writes
        hwset(1, 32'hFFFF_FFFF);
        acc(0, 4, 4, 0);
        chk("R8 set raises only w1c bits", r_data, 32'hF910_0147);
        hwset(0, 32'hFFFF_FFFF);
        acc(0, 0, 4, 0);
        chk("R8 set ignored on read-only dword", r_data, {DID, VID});
        acc(1, 7, 1, 32'h08);
        acc(0, 4, 4, 0);
        chk("R7 write one clears", r_data, 32'hF110_0147);
        acc(1, 7, 1, 32'h00);
        acc(0, 4, 4, 0);
        chk("R7 write zero keeps", r_data, 32'hF110_0147);
        set_valid = 1'b1; set_idx = 10'd1; set_bits = 32'h0800_0000;
        acc(1, 7, 1, 32'h18);
        acc(0, 4, 4, 0);
        chk("R8 set beats same-cycle clear", r_data, 32'hE910_0147);

        // R11: capability status dwords
        hwset(18, 32'hFFFF_FFFF);
        acc(0, 72, 4, 0);
        chk("R11 device status set", r_data, 32'h000F_0000);
        acc(1, 72, 4, 32'hFFFF_FFFF);
        acc(0, 72, 4, 0);
        chk("R11 device status clear", r_data, 32'h0000_FFFF);
        hwset(20, 32'hFFFF_FFFF);
        acc(0, 80, 4, 0);
        chk("R11 link status set", r_data, 32'hC000_0000);
        acc(1, 80, 4, 32'hFFFF_FFFF);
        acc(0, 80, 4, 0);
        chk("R11 link control/status", r_data, 32'h0000_0FFB);
        hwset(24, 32'hFFFF_FFFF);
        acc(0, 96, 2, 0);
        chk("R11 root status low half", r_data, 32'h0);
        acc(0, 98, 2, 0);
        chk("R11 root PME set", r_data, 32'h0001);
        acc(1, 96, 4, 32'hFFFF_FFFF);
        acc(0, 96, 4, 0);
        chk("R11 root PME clear", r_data, 32'h0);

        // R9: outside the implemented region
        acc(1, 124, 4, 32'hFFFF_FFFF);
        acc(0, 124, 4, 0);
        chk("R9 end of capability reads zero", r_data, 32'h0);
        acc(0, 128, 3, 0);
        chk("R9 outside bad size no error", {31'b0, r_err}, 32'h0);
        acc(1, 64, 4, 32'hFFFF_FFFF);
        acc(0, 64, 4, 0);
        chk("R9 no-cap write at 0x40 dropped", n_data, 32'h0);
        chk("R9 no-cap no error", {31'b0, n_err}, 32'h0);
        chk("R1 cap id keeps value", r_data, 32'h0142_0010);
        acc(0, 4092, 4, 0);
        chk("R9 top of space reads zero", r_data, 32'h0);

        @(negedge clk);
        chk("R12 no response after idle", {31'b0, rsp_valid}, 32'h0);
        summary();
    end
endmodule